// File: doc/BRIEF.md
# Receive Character FIFO with Per-Character Error Tags

This block is the receive-side character store of a 16550-style serial port. The receive deserializer hands it one assembled character at a time. Each character comes with three error-status bits: parity error, framing error and break. The block queues up to sixteen such entries in arrival order. The register interface pops entries with a read strobe. The character and the error bits of the oldest entry are always on the outputs, so line-status reporting can read the head's errors before the character is taken.

A two-bit code selects a fill threshold. While receive interrupts are enabled and the stored count is at or above that threshold, the block drives an interrupt request. Storing goes on past the threshold until all sixteen entries are in use. A character offered to a full store is thrown away and an overrun flag is raised. The flag is held until line status is read. A clear input empties the store in one clock and leaves the overrun flag as it is.

Top module: `rx_err_fifo`

## Requirements
- R1: After reset, count is 0, empty is 1, overrun is 0 and irq is 0.
- R2: Entries leave in the order they arrived. rd_data and head_err always show the oldest entry, with head_err bit 0 = parity, bit 1 = framing, bit 2 = break. A read strobe removes that entry. A read strobe while empty changes nothing, and while empty rd_data and head_err read 0.
- R3: count equals the number of stored entries, never exceeds 16, and empty is 1 exactly when count is 0. Writes are accepted above the threshold until count is 16.
- R4: A write to a full store with no read in the same cycle is dropped: count stays 16 and the stored contents and their order are unchanged.
- R5: The dropped write of R4 sets overrun on the next cycle. overrun holds until a cycle with lsr_rd high and no new dropped write; a dropped write in the same cycle as lsr_rd leaves overrun set.
- R6: trig_sel selects the threshold: 0 -> 1, 1 -> 4, 2 -> 8, 3 -> 14 entries. irq is 1 when irq_en is 1 and count is at or above the threshold.
- R7: irq drops in the same cycle that count goes below the threshold, and whenever irq_en is 0.
- R8: clr makes count 0 and empty 1 on the next cycle. Any read or write in that cycle is discarded. clr neither sets nor clears overrun.
- R9: A write together with a read on a full store is accepted. The head leaves, the new entry joins the tail, count stays 16 and overrun is not set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Character from the deserializer is valid |
| wr_data | input | 8 | Received character |
| wr_err | input | 3 | Error bits: bit0 parity, bit1 framing, bit2 break |
| rd_en | input | 1 | Pop the head entry |
| clr | input | 1 | Empty the store |
| lsr_rd | input | 1 | Line status read; clears overrun |
| trig_sel | input | 2 | Threshold code |
| irq_en | input | 1 | Receive interrupt enable |
| rd_data | output | 8 | Head character, 0 when empty |
| head_err | output | 3 | Head error bits, 0 when empty |
| empty | output | 1 | No entries stored |
| count | output | 5 | Number of stored entries |
| overrun | output | 1 | Sticky overrun flag |
| irq | output | 1 | Data-available interrupt request |

## Verification
Every stored-state result (count, empty, head character and errors, overrun) changes on the first rising edge after the stimulus that causes it. irq follows count and the irq_en and trig_sel inputs with no added register. The bench drives inputs one time unit after a rising edge and updates a queue-based model on that same edge. It then compares every output at the falling edge, so each result is checked in exactly the cycle it is due. The directed phases fill to full, drop writes, read status together with a new drop, read and write together while full, and clear while overrun is pending. A long random phase then mixes all inputs under the same per-cycle comparison.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

    localparam int CHAR_W = 8;
    localparam int ERR_W  = 3;

    localparam int ERR_PARITY = 0;
    localparam int ERR_FRAME  = 1;
    localparam int ERR_BREAK  = 2;

    typedef enum logic [1:0] {
        TRIG_ONE     = 2'd0,
        TRIG_QUARTER = 2'd1,
        TRIG_HALF    = 2'd2,
        TRIG_NEAR    = 2'd3
    } trig_code_e;

    typedef struct packed {
        logic [ERR_W-1:0]  err;
        logic [CHAR_W-1:0] data;
    } rx_entry_t;

endpackage

// File: rtl/rxf_store.sv
module rxf_store #(
    parameter int DEPTH = 16,
    parameter int W     = 11,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);

    logic [W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];

endmodule

// File: rtl/rxf_thresh.sv
module rxf_thresh #(
    parameter int DEPTH = 16,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic [1:0]       trig_sel,
    output logic [CNT_W-1:0] level
);
    import rxf_pkg::*;

    always_comb begin
        case (trig_code_e'(trig_sel))
            TRIG_ONE:     level = CNT_W'(1);
            TRIG_QUARTER: level = CNT_W'(DEPTH / 4);
            TRIG_HALF:    level = CNT_W'(DEPTH / 2);
            default:      level = CNT_W'(DEPTH - 2);
        endcase
    end

endmodule

// File: rtl/rx_err_fifo.sv
module rx_err_fifo #(
    parameter int DEPTH = 16,
    localparam int AW    = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int DW    = rxf_pkg::CHAR_W,
    localparam int EW    = rxf_pkg::ERR_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [DW-1:0]    wr_data,
    input  logic [EW-1:0]    wr_err,
    input  logic             rd_en,
    input  logic             clr,
    input  logic             lsr_rd,
    input  logic [1:0]       trig_sel,
    input  logic             irq_en,
    output logic [DW-1:0]    rd_data,
    output logic [EW-1:0]    head_err,
    output logic             empty,
    output logic [CNT_W-1:0] count,
    output logic             overrun,
    output logic             irq
);
    import rxf_pkg::*;

    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
    localparam logic [AW-1:0]    LAST_IDX = AW'(DEPTH - 1);

    typedef struct packed {
        logic [AW-1:0]    wp;
        logic [AW-1:0]    rp;
        logic [CNT_W-1:0] cnt;
        logic             ovr;
    } state_t;

    state_t st_d, st_q;

    logic             full_w;
    logic             rd_ok_w;
    logic             wr_ok_w;
    logic             drop_w;
    logic [CNT_W-1:0] level_w;
    rx_entry_t        wr_ent_w;
    rx_entry_t        head_w;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == LAST_IDX) ? '0 : p + AW'(1);
    endfunction

    always_comb begin
        st_d    = st_q;
        full_w  = (st_q.cnt == FULL_CNT);
        rd_ok_w = rd_en && (st_q.cnt != '0);
        wr_ok_w = wr_en && (!full_w || rd_ok_w);
        drop_w  = wr_en && full_w && !rd_ok_w;

        if (clr) begin
            st_d.wp  = '0;
            st_d.rp  = '0;
            st_d.cnt = '0;
        end else begin
            if (rd_ok_w) begin
                st_d.rp = bump(st_q.rp);
            end
            if (wr_ok_w) begin
                st_d.wp = bump(st_q.wp);
            end
            st_d.cnt = st_q.cnt + CNT_W'(wr_ok_w) - CNT_W'(rd_ok_w);
        end

        if (drop_w) begin
            st_d.ovr = 1'b1;
        end else if (lsr_rd) begin
            st_d.ovr = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_ent_w.data = wr_data;
    assign wr_ent_w.err  = wr_err;

    rxf_store #(
        .DEPTH (DEPTH),
        .W     ($bits(rx_entry_t))
    ) u_store (
        .clk   (clk),
        .we    (wr_ok_w && !clr),
        .waddr (st_q.wp),
        .wdata (wr_ent_w),
        .raddr (st_q.rp),
        .rdata (head_w)
    );

    rxf_thresh #(
        .DEPTH (DEPTH)
    ) u_thresh (
        .trig_sel (trig_sel),
        .level    (level_w)
    );

    assign empty    = (st_q.cnt == '0);
    assign count    = st_q.cnt;
    assign overrun  = st_q.ovr;
    assign irq      = irq_en && (st_q.cnt >= level_w);
    assign rd_data  = empty ? '0 : head_w.data;
    assign head_err = empty ? '0 : head_w.err;

endmodule

// File: rtl/rx_err_fifo_chk.sv
module rx_err_fifo_chk #(
    parameter int DEPTH = 16,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic             rd_en,
    input logic             clr,
    input logic             lsr_rd,
    input logic [1:0]       trig_sel,
    input logic             irq_en,
    input logic [CNT_W-1:0] count,
    input logic             overrun,
    input logic             irq
);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    logic [CNT_W-1:0] lvl;
    always_comb begin
        unique case (trig_sel)
            2'd0:    lvl = CNT_W'(1);
            2'd1:    lvl = CNT_W'(DEPTH / 4);
            2'd2:    lvl = CNT_W'(DEPTH / 2);
            default: lvl = CNT_W'(DEPTH - 2);
        endcase
    end

    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        count <= FULL_CNT);

    a_r4_full_drop_keeps_count: assert property (@(posedge clk) disable iff (!rst_n)
        (count == FULL_CNT && wr_en && !rd_en && !clr) |=> count == FULL_CNT);

    a_r5_overrun_on_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (count == FULL_CNT && wr_en && !rd_en) |=> overrun);

    a_r5_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !lsr_rd) |=> overrun);

    a_r6_irq_at_level: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_en && count >= lvl) |-> irq);

    a_r7_irq_below_level: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_en || count < lvl) |-> !irq);

    a_r8_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> count == '0);

    a_r8_clear_keeps_overrun: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !lsr_rd && !(wr_en && count == FULL_CNT && !rd_en)) |=> $stable(overrun));

    a_r9_full_rd_wr: assert property (@(posedge clk) disable iff (!rst_n)
        (count == FULL_CNT && wr_en && rd_en && !clr && !overrun && !lsr_rd)
            |=> (count == FULL_CNT && !overrun));

endmodule

bind rx_err_fifo rx_err_fifo_chk #(.DEPTH(DEPTH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .clr      (clr),
    .lsr_rd   (lsr_rd),
    .trig_sel (trig_sel),
    .irq_en   (irq_en),
    .count    (count),
    .overrun  (overrun),
    .irq      (irq)
);

// File: tb/sim_rx_err_fifo.sv
`timescale 1ns/1ps
module sim_rx_err_fifo;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       wr_en, rd_en, clr, lsr_rd, irq_en;
    logic [7:0] wr_data;
    logic [2:0] wr_err;
    logic [1:0] trig_sel;
    logic [7:0] rd_data;
    logic [2:0] head_err;
    logic       empty, overrun, irq;
    logic [4:0] count;

    int n_chk  = 0;
    int n_fail = 0;
    string cur_tag = "R1";
    bit finished = 0;

    always #2.5 clk = ~clk;

    rx_err_fifo u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .wr_err(wr_err),
        .rd_en(rd_en), .clr(clr), .lsr_rd(lsr_rd), .trig_sel(trig_sel), .irq_en(irq_en),
        .rd_data(rd_data), .head_err(head_err), .empty(empty), .count(count),
        .overrun(overrun), .irq(irq)
    );

    // behavioural reference: queue of {err, data}
    logic [10:0] mq[$];
    bit          m_ovr;

    function automatic int lvl_of(input logic [1:0] s);
        case (s)
            2'd0: return 1;
            2'd1: return 4;
            2'd2: return 8;
            default: return 14;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            mq.delete();
            m_ovr = 0;
        end else begin
            bit rd_ok, wr_ok, drop;
            rd_ok = rd_en && (mq.size() > 0);
            wr_ok = wr_en && ((mq.size() < 16) || rd_ok);
            drop  = wr_en && (mq.size() == 16) && !rd_ok;
            if (clr) mq.delete();
            else begin
                if (rd_ok) void'(mq.pop_front());
                if (wr_ok) mq.push_back({wr_err, wr_data});
            end
            if (drop) m_ovr = 1;
            else if (lsr_rd) m_ovr = 0;
        end
    end

    task automatic chk(input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", cur_tag, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n === 1'b1 && !finished) begin
            int sz;
            sz = mq.size();
            chk("count", int'(count), sz);
            chk("empty", int'(empty), (sz == 0) ? 1 : 0);
            chk("rd_data", int'(rd_data), (sz == 0) ? 0 : int'(mq[0][7:0]));
            chk("head_err", int'(head_err), (sz == 0) ? 0 : int'(mq[0][10:8]));
            chk("overrun", int'(overrun), int'(m_ovr));
            chk("irq", int'(irq), (irq_en && sz >= lvl_of(trig_sel)) ? 1 : 0);
        end
    end

    task automatic drive(input bit w, input logic [7:0] d, input logic [2:0] e,
                         input bit r, input bit c, input bit l);
        wr_en = w; wr_data = d; wr_err = e; rd_en = r; clr = c; lsr_rd = l;
        @(posedge clk); #1;
    endtask

    task automatic idle();
        drive(0, 8'h00, 3'b000, 0, 0, 0);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            finished = 1;
            cur_tag = "watchdog";
            chk("timeout", 1, 0);
            summary();
            $finish;
        end
    end

    initial begin
        rst_n = 0; wr_en = 0; rd_en = 0; clr = 0; lsr_rd = 0; irq_en = 0;
        wr_data = 0; wr_err = 0; trig_sel = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 count", int'(count), 0);
        chk("R1 empty", int'(empty), 1);
        chk("R1 overrun", int'(overrun), 0);
        chk("R1 irq", int'(irq), 0);
        @(posedge clk); #1;

        // R2 ordering, error tags, read on empty
        cur_tag = "R2";
        drive(1, 8'hA5, 3'b001, 0, 0, 0);
        drive(1, 8'h3C, 3'b010, 0, 0, 0);
        drive(1, 8'h81, 3'b100, 0, 0, 0);
        idle();
        repeat (3) drive(0, 0, 0, 1, 0, 0);
        repeat (2) drive(0, 0, 0, 1, 0, 0);
        @(negedge clk);
        chk("R2 read on empty keeps empty", int'(empty), 1);
        @(posedge clk); #1;

        // R6 threshold mapping while filling to full (R3)
        cur_tag = "R6";
        irq_en = 1; trig_sel = 2'd3;
        for (int i = 0; i < 16; i++) drive(1, 8'(i * 7 + 1), 3'(i), 0, 0, 0);
        idle();
        cur_tag = "R3";
        @(negedge clk);
        chk("R3 full count", int'(count), 16);
        @(posedge clk); #1;
        cur_tag = "R6";
        for (int s = 0; s < 4; s++) begin trig_sel = 2'(s); idle(); end

        // R7 deassert on enable low and on falling below level
        cur_tag = "R7";
        irq_en = 0; idle(); idle();
        irq_en = 1; trig_sel = 2'd2;
        repeat (9) drive(0, 0, 0, 1, 0, 0);
        @(negedge clk);
        chk("R7 irq low at 7 entries", int'(irq), 0);
        @(posedge clk); #1;
        cur_tag = "R3";
        for (int i = 0; i < 9; i++) drive(1, 8'(8'hC0 + i), 3'(7 - (i % 8)), 0, 0, 0);

        // R4/R5 dropped writes and overrun
        cur_tag = "R4";
        drive(1, 8'hEE, 3'b111, 0, 0, 0);
        drive(1, 8'hDD, 3'b110, 0, 0, 0);
        cur_tag = "R5";
        @(negedge clk);
        chk("R5 overrun after drop", int'(overrun), 1);
        @(posedge clk); #1;
        idle();
        drive(1, 8'h11, 3'b000, 0, 0, 1);   // drop together with status read
        drive(0, 0, 0, 0, 0, 1);
        idle();

        // R9 read and write together while full
        cur_tag = "R9";
        for (int i = 0; i < 3; i++) drive(1, 8'(8'h50 + i), 3'(i), 1, 0, 0);
        @(negedge clk);
        chk("R9 overrun stays clear", int'(overrun), 0);
        @(posedge clk); #1;

        // R8 clear with pending overrun
        cur_tag = "R5";
        drive(1, 8'h77, 3'b011, 0, 0, 0);
        cur_tag = "R8";
        drive(0, 0, 0, 1, 1, 0);
        @(negedge clk);
        chk("R8 empty after clear", int'(empty), 1);
        chk("R8 overrun kept", int'(overrun), 1);
        @(posedge clk); #1;
        drive(0, 0, 0, 0, 0, 1);

        // R4 drained contents check via per-cycle compare
        cur_tag = "R4";
        for (int i = 0; i < 16; i++) drive(1, 8'(8'h20 + i), 3'(i % 8), 0, 0, 0);
        drive(1, 8'hFF, 3'b111, 0, 0, 0);
        repeat (17) drive(0, 0, 0, 1, 0, 0);

        // R3 random mix
        cur_tag = "R3";
        for (int i = 0; i < 4000; i++) begin
            int p;
            p = $urandom_range(0, 99);
            if (p < 3) irq_en = ~irq_en;
            if (p > 95) trig_sel = 2'($urandom_range(0, 3));
            drive($urandom_range(0, 99) < 55, 8'($urandom), 3'($urandom),
                  $urandom_range(0, 99) < 45, $urandom_range(0, 299) == 0,
                  $urandom_range(0, 19) == 0);
        end
        idle();

        finished = 1;
        summary();
        $finish;
    end

endmodule